// File: doc/BRIEF.md
# PCI Target Window Access Controller

This block sits behind the PCI target state machine and, for every target request already steered to one of four address windows, decides whether the window may be used and how. Windows 0 to 2 map memory space and window 3 maps I/O space. For each request it produces a claim decision, an error flag for unsupported burst reads, and a command for the internal bus side. That command carries the read or write, the transfer length in 32-bit beats, the byte enables and the write data. Returning read data passes through the same per-window byte-lane swap.

Configuration is held in two register groups with separate load strobes. The control group holds the target-ready bit, the host/satellite mode bit, the status-copy space bits and the window enables. The lane group holds the memory-window prefetch enables, the per-window swap bits and the prefetch length code. The PCI command-register space bits arrive as live inputs. All outputs are registered and appear one clock after the request.

Top module: `pci_tgt_window_ctl`

## Requirements
- R1: A request to memory window 0, 1 or 2 is claimed only when the target-ready bit, the selected memory-space enable and that window's enable bit (cfg_win_en[w]) are all 1.
- R2: A request to window 3 (the I/O window, req_win = 3) is claimed only when the target-ready bit, the selected I/O-space enable and cfg_win_en[3] are all 1.
- R3: With cfg_host = 1 the memory and I/O space enables come from cfg_stat_mem and cfg_stat_io. With cfg_host = 0 they come from cmd_mem_sp and cmd_io_sp.
- R4: After reset the control group clears the target-ready bit, the status-copy bits and all window enables, and sets host mode. The lane group enables prefetch on windows 0 and 1, disables it on window 2, clears all swap bits and sets the length code to 3.
- R5: A claimed read to a memory window whose prefetch bit is set is a prefetch read whether single or burst. It asserts ib_prefetch and all four byte enables, and ib_len = length code + 1 beats.
- R6: The I/O window never prefetches, whatever the lane register holds.
- R7: A claimed burst read (req_burst = 1) to a window without prefetch is claimed with rsp_err = 1, and no internal request is made.
- R8: An unclaimed request gives rsp_claim = 0, rsp_err = 0 and ib_req = 0.
- R9: A claimed write or a non-prefetch read is one beat (ib_len = 1). Its byte enables and write data pass through unchanged, or reversed lane for lane (byte 0 swaps with byte 3, byte 1 with byte 2) when the window's swap bit is set.
- R10: Read data presented with rd_in_valid appears one clock later on rd_out_data, lane-reversed when the swap bit of rd_in_win is set.
- R11: Outputs for a request appear one clock after it, decoded with the configuration in force before any load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load_ctl | input | 1 | Load the control register group |
| cfg_ready | input | 1 | Target-ready bit |
| cfg_host | input | 1 | 1 = host mode, 0 = satellite mode |
| cfg_stat_mem | input | 1 | Status-copy memory space enable |
| cfg_stat_io | input | 1 | Status-copy I/O space enable |
| cfg_win_en | input | 4 | Per-window enables, bit 3 = I/O window |
| cfg_load_lane | input | 1 | Load the lane register group |
| cfg_pf_en | input | 3 | Prefetch enables for memory windows 0..2 |
| cfg_swap | input | 4 | Per-window byte-lane swap |
| cfg_pf_code | input | 4 | Prefetch length code (beats = code + 1) |
| cmd_mem_sp | input | 1 | Command-register memory space bit |
| cmd_io_sp | input | 1 | Command-register I/O space bit |
| req_valid | input | 1 | Request present |
| req_win | input | 2 | Target window, 3 = I/O |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = burst transfer |
| req_be | input | 4 | Byte enables, bit 0 = byte 0 |
| req_wdata | input | 32 | Write data |
| rd_in_valid | input | 1 | Internal read data valid |
| rd_in_win | input | 2 | Window the read data belongs to |
| rd_in_data | input | 32 | Internal read data |
| rsp_valid | output | 1 | Decision valid |
| rsp_claim | output | 1 | Request claimed |
| rsp_err | output | 1 | Unsupported burst read |
| ib_req | output | 1 | Internal bus request |
| ib_write | output | 1 | Internal request is a write |
| ib_prefetch | output | 1 | Internal request is a prefetch read |
| ib_len | output | 5 | Internal transfer length in beats |
| ib_be | output | 4 | Internal byte enables |
| ib_wdata | output | 32 | Internal write data |
| rd_out_valid | output | 1 | Returned read data valid |
| rd_out_data | output | 32 | Returned read data after swap |

## Verification
A configuration load and a request can land on the same clock edge. In that case the request must be judged under the old settings. The bench enables window 0 and then, on one edge, issues a read to it while the control load clears that window's enable. The read is expected to be claimed, and a second read one cycle later is expected to be refused. The read-return swap and the request decode can also share a cycle, so returned data is checked while the request path is busy.

// File: rtl/pci_tw_pkg.sv
// Shared constants and types for the PCI target window controller.
// Assumes three memory windows followed by one I/O window at the top index.
package pci_tw_pkg;
    localparam int TW_NMEM   = 3;
    localparam int TW_NWIN   = TW_NMEM + 1;
    localparam int TW_IOWIN  = TW_NMEM;
    localparam int TW_LANES  = 4;
    localparam int TW_DW     = 8 * TW_LANES;
    localparam int TW_CODE_W = 4;
    localparam int TW_LEN_W  = TW_CODE_W + 1;
    localparam int TW_SEL_W  = $clog2(TW_NWIN);

    typedef struct packed {
        logic                ready;
        logic                host;
        logic                stat_mem;
        logic                stat_io;
        logic [TW_NWIN-1:0]  win_en;
    } tw_ctl_t;

    typedef struct packed {
        logic [TW_NMEM-1:0]   pf_en;
        logic [TW_NWIN-1:0]   swap;
        logic [TW_CODE_W-1:0] pf_code;
    } tw_lane_t;

    localparam tw_ctl_t TW_CTL_RST = '{ready: 1'b0, host: 1'b1, stat_mem: 1'b0,
                                       stat_io: 1'b0, win_en: '0};
    localparam tw_lane_t TW_LANE_RST = '{pf_en: 3'b011, swap: '0,
                                         pf_code: TW_CODE_W'(3)};

    typedef struct packed {
        logic                claim;
        logic                err;
        logic                go;
        logic                pf;
        logic                swap;
        logic [TW_LEN_W-1:0] len;
    } tw_dec_t;
endpackage

// File: rtl/pci_tw_cfg.sv
// Configuration holding registers for the window controller.
// Two groups load independently so either can keep its reset value.
// Assumes loads are single-cycle strobes; a load takes effect next cycle.
module pci_tw_cfg
    import pci_tw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_ctl,
    input  tw_ctl_t  ctl_in,
    input  logic     load_lane,
    input  tw_lane_t lane_in,
    output tw_ctl_t  ctl_q,
    output tw_lane_t lane_q
);
    // Control group register: readiness, mode, space copies, window enables.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctl_q <= TW_CTL_RST;
        else if (load_ctl) ctl_q <= ctl_in;
    end

    // Lane group register: prefetch enables, swap bits, prefetch length.
    always_ff @(posedge clk) begin
        if (!rst_n)         lane_q <= TW_LANE_RST;
        else if (load_lane) lane_q <= lane_in;
    end
endmodule

// File: rtl/pci_tw_swap.sv
// Lane reverser: reverses the order of LANES lanes of LANE_W bits each
// when swap_en is set, else passes through. Used for data and byte enables.
module pci_tw_swap #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int W     = LANES * LANE_W
) (
    input  logic         swap_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // One mux per lane: straight or mirrored source lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign dout[l*LANE_W +: LANE_W] = swap_en ? din[(LANES-1-l)*LANE_W +: LANE_W]
                                                  : din[l*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/pci_tw_decode.sv
// Combinational window decision: per-window enable, prefetch permission,
// burst-read error and internal transfer length.
// Assumes req_win is already resolved by address matching upstream.
module pci_tw_decode
    import pci_tw_pkg::*;
(
    input  tw_ctl_t              ctl,
    input  tw_lane_t             lane,
    input  logic                 cmd_mem_sp,
    input  logic                 cmd_io_sp,
    input  logic                 req_valid,
    input  logic [TW_SEL_W-1:0]  req_win,
    input  logic                 req_write,
    input  logic                 req_burst,
    output tw_dec_t              dec
);
    logic                sp_mem;
    logic                sp_io;
    logic [TW_NWIN-1:0]  win_ok;
    logic [TW_NWIN-1:0]  win_pf;

    // Space enable source follows the host/satellite mode bit.
    always_comb begin
        sp_mem = ctl.host ? ctl.stat_mem : cmd_mem_sp;
        sp_io  = ctl.host ? ctl.stat_io  : cmd_io_sp;
    end

    // Per-window usability and prefetch permission; the I/O window never prefetches.
    for (genvar w = 0; w < TW_NWIN; w++) begin : g_win
        if (w < TW_NMEM) begin : g_mem
            assign win_ok[w] = ctl.ready & sp_mem & ctl.win_en[w];
            assign win_pf[w] = lane.pf_en[w];
        end else begin : g_io
            assign win_ok[w] = ctl.ready & sp_io & ctl.win_en[w];
            assign win_pf[w] = 1'b0;
        end
    end

    // Final decision for the selected window.
    always_comb begin
        dec.claim = req_valid & win_ok[req_win];
        dec.err   = dec.claim & ~req_write & req_burst & ~win_pf[req_win];
        dec.go    = dec.claim & ~dec.err;
        dec.pf    = dec.go & ~req_write & win_pf[req_win];
        dec.swap  = lane.swap[req_win];
        dec.len   = dec.pf ? (TW_LEN_W'(lane.pf_code) + TW_LEN_W'(1)) : TW_LEN_W'(1);
    end

    // R6: a prefetch decision is never made for the I/O window.
    always_comb begin
        assert_io_never_pf_R6: assert (!(dec.pf && req_win == TW_SEL_W'(TW_IOWIN)));
    end
endmodule

// File: rtl/pci_tgt_window_ctl.sv
// PCI target window access controller, top level.
// Registers the window decision and the swapped internal command one cycle
// after the request, and swaps returned read data per window.
// Assumes one request per cycle and that read return carries its window.
module pci_tgt_window_ctl
    import pci_tw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_load_ctl,
    input  logic                 cfg_ready,
    input  logic                 cfg_host,
    input  logic                 cfg_stat_mem,
    input  logic                 cfg_stat_io,
    input  logic [TW_NWIN-1:0]   cfg_win_en,
    input  logic                 cfg_load_lane,
    input  logic [TW_NMEM-1:0]   cfg_pf_en,
    input  logic [TW_NWIN-1:0]   cfg_swap,
    input  logic [TW_CODE_W-1:0] cfg_pf_code,
    input  logic                 cmd_mem_sp,
    input  logic                 cmd_io_sp,
    input  logic                 req_valid,
    input  logic [TW_SEL_W-1:0]  req_win,
    input  logic                 req_write,
    input  logic                 req_burst,
    input  logic [TW_LANES-1:0]  req_be,
    input  logic [TW_DW-1:0]     req_wdata,
    input  logic                 rd_in_valid,
    input  logic [TW_SEL_W-1:0]  rd_in_win,
    input  logic [TW_DW-1:0]     rd_in_data,
    output logic                 rsp_valid,
    output logic                 rsp_claim,
    output logic                 rsp_err,
    output logic                 ib_req,
    output logic                 ib_write,
    output logic                 ib_prefetch,
    output logic [TW_LEN_W-1:0]  ib_len,
    output logic [TW_LANES-1:0]  ib_be,
    output logic [TW_DW-1:0]     ib_wdata,
    output logic                 rd_out_valid,
    output logic [TW_DW-1:0]     rd_out_data
);
    tw_ctl_t               ctl_q;
    tw_lane_t              lane_q;
    tw_ctl_t               ctl_in;
    tw_lane_t              lane_in;
    tw_dec_t               dec;
    logic [TW_LANES-1:0]   be_sw;
    logic [TW_DW-1:0]      wdata_sw;
    logic [TW_DW-1:0]      rdata_sw;
    logic [TW_SEL_W-1:0]   q_win;

    // Pack the configuration pins into the register group types.
    always_comb begin
        ctl_in  = '{ready: cfg_ready, host: cfg_host, stat_mem: cfg_stat_mem,
                    stat_io: cfg_stat_io, win_en: cfg_win_en};
        lane_in = '{pf_en: cfg_pf_en, swap: cfg_swap, pf_code: cfg_pf_code};
    end

    pci_tw_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_ctl  (cfg_load_ctl),
        .ctl_in    (ctl_in),
        .load_lane (cfg_load_lane),
        .lane_in   (lane_in),
        .ctl_q     (ctl_q),
        .lane_q    (lane_q)
    );

    pci_tw_decode u_dec (
        .ctl        (ctl_q),
        .lane       (lane_q),
        .cmd_mem_sp (cmd_mem_sp),
        .cmd_io_sp  (cmd_io_sp),
        .req_valid  (req_valid),
        .req_win    (req_win),
        .req_write  (req_write),
        .req_burst  (req_burst),
        .dec        (dec)
    );

    pci_tw_swap #(.LANES(TW_LANES), .LANE_W(8)) u_wswap (
        .swap_en (dec.swap),
        .din     (req_wdata),
        .dout    (wdata_sw)
    );

    pci_tw_swap #(.LANES(TW_LANES), .LANE_W(1)) u_beswap (
        .swap_en (dec.swap),
        .din     (req_be),
        .dout    (be_sw)
    );

    pci_tw_swap #(.LANES(TW_LANES), .LANE_W(8)) u_rswap (
        .swap_en (lane_q.swap[rd_in_win]),
        .din     (rd_in_data),
        .dout    (rdata_sw)
    );

    // Register the decision and the internal bus command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_claim   <= 1'b0;
            rsp_err     <= 1'b0;
            ib_req      <= 1'b0;
            ib_write    <= 1'b0;
            ib_prefetch <= 1'b0;
            ib_len      <= '0;
            ib_be       <= '0;
            ib_wdata    <= '0;
            q_win       <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_claim   <= dec.claim;
            rsp_err     <= dec.err;
            ib_req      <= dec.go;
            ib_write    <= dec.go & req_write;
            ib_prefetch <= dec.pf;
            ib_len      <= dec.go ? dec.len : '0;
            ib_be       <= !dec.go ? '0 : (dec.pf ? '1 : be_sw);
            ib_wdata    <= (dec.go & req_write) ? wdata_sw : '0;
            q_win       <= req_win;
        end
    end

    // Register the swapped read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_out_valid <= 1'b0;
            rd_out_data  <= '0;
        end else begin
            rd_out_valid <= rd_in_valid;
            rd_out_data  <= rd_in_valid ? rdata_sw : '0;
        end
    end

    // R7: an error response never launches an internal transfer.
    assert_err_no_ib_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !ib_req);
    // R8: an unclaimed request stays silent.
    assert_unclaimed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_claim) |-> (!ib_req && !rsp_err));
    // R9: non-prefetch transfers are a single beat.
    assert_single_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_prefetch) |-> ib_len == TW_LEN_W'(1));
    // R6: no prefetch response for the I/O window.
    assert_io_no_prefetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ib_prefetch |-> q_win != TW_SEL_W'(TW_IOWIN));
    // R10: returned data follows its input strobe by one cycle.
    assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out_valid |-> $past(rd_in_valid));
    // R11: a decision follows its request by one cycle.
    assert_rsp_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));
endmodule

// File: tb/pci_tgt_window_ctl_tb.sv
module pci_tgt_window_ctl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load_ctl = 0, cfg_ready = 0, cfg_host = 0, cfg_stat_mem = 0, cfg_stat_io = 0;
    logic [3:0] cfg_win_en = 0;
    logic cfg_load_lane = 0;
    logic [2:0] cfg_pf_en = 0;
    logic [3:0] cfg_swap = 0;
    logic [3:0] cfg_pf_code = 0;
    logic cmd_mem_sp = 0, cmd_io_sp = 0;
    logic req_valid = 0, req_write = 0, req_burst = 0;
    logic [1:0] req_win = 0;
    logic [3:0] req_be = 0;
    logic [31:0] req_wdata = 0;
    logic rd_in_valid = 0;
    logic [1:0] rd_in_win = 0;
    logic [31:0] rd_in_data = 0;
    logic rsp_valid, rsp_claim, rsp_err, ib_req, ib_write, ib_prefetch;
    logic [4:0] ib_len;
    logic [3:0] ib_be;
    logic [31:0] ib_wdata;
    logic rd_out_valid;
    logic [31:0] rd_out_data;
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pci_tgt_window_ctl u_dut (.*);

    task automatic chk(string rq, string what, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s actual %0h expected %0h", rq, what, got, exp);
        end
    endtask

    function automatic logic [31:0] rev32(logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic logic [3:0] rev4(logic [3:0] b);
        return {b[0], b[1], b[2], b[3]};
    endfunction

    task automatic load_ctl(logic rdy, logic host, logic smem, logic sio, logic [3:0] en);
        @(negedge clk);
        cfg_load_ctl = 1; cfg_ready = rdy; cfg_host = host;
        cfg_stat_mem = smem; cfg_stat_io = sio; cfg_win_en = en;
        @(negedge clk);
        cfg_load_ctl = 0;
    endtask

    task automatic load_lane(logic [2:0] pf, logic [3:0] sw, logic [3:0] code);
        @(negedge clk);
        cfg_load_lane = 1; cfg_pf_en = pf; cfg_swap = sw; cfg_pf_code = code;
        @(negedge clk);
        cfg_load_lane = 0;
    endtask

    // Issue one request and check the registered result one edge later.
    task automatic req(string rq, logic [1:0] w, logic wr, logic bu, logic [3:0] be,
                       logic [31:0] wd, logic claim, logic err, logic go, logic pf,
                       logic [4:0] len, logic [3:0] ebe, logic [31:0] ewd);
        @(negedge clk);
        req_valid = 1; req_win = w; req_write = wr; req_burst = bu; req_be = be; req_wdata = wd;
        @(posedge clk);
        #1;
        req_valid = 0;
        chk(rq, "rsp_valid", rsp_valid, 1);
        chk(rq, "rsp_claim", rsp_claim, claim);
        chk(rq, "rsp_err", rsp_err, err);
        chk(rq, "ib_req", ib_req, go);
        chk(rq, "ib_write", ib_write, go & wr);
        chk(rq, "ib_prefetch", ib_prefetch, pf);
        chk(rq, "ib_len", ib_len, go ? len : 5'd0);
        chk(rq, "ib_be", ib_be, go ? ebe : 4'd0);
        chk(rq, "ib_wdata", ib_wdata, (go & wr) ? ewd : 32'd0);
    endtask

    task automatic unclaimed(string rq, logic [1:0] w);
        req(rq, w, 0, 0, 4'hF, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        chk("R4", "rsp_valid at reset", rsp_valid, 0);
        chk("R4", "ib_req at reset", ib_req, 0);
        chk("R4", "rd_out_valid at reset", rd_out_valid, 0);
        unclaimed("R4 ready cleared", 0);
        unclaimed("R4 ready cleared io", 3);
    endtask

    task automatic t_defaults();
        load_ctl(1, 1, 1, 1, 4'hF);
        req("R4 R5 win0 pf default", 0, 0, 0, 4'h1, 0, 1, 0, 1, 1, 5'd4, 4'hF, 0);
        req("R4 R5 win1 pf default", 1, 0, 1, 4'h2, 0, 1, 0, 1, 1, 5'd4, 4'hF, 0);
        req("R4 R9 win2 no pf no swap", 2, 0, 0, 4'h3, 0, 1, 0, 1, 0, 5'd1, 4'h3, 0);
        req("R7 win2 burst read", 2, 0, 1, 4'hF, 0, 1, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_enable();
        load_ctl(0, 1, 1, 1, 4'hF);
        unclaimed("R1 ready off", 1);
        unclaimed("R2 ready off", 3);
        load_ctl(1, 1, 0, 1, 4'hF);
        unclaimed("R1 mem space off", 0);
        req("R2 io with mem off", 3, 0, 0, 4'h1, 0, 1, 0, 1, 0, 5'd1, 4'h1, 0);
        load_ctl(1, 1, 1, 0, 4'hF);
        unclaimed("R2 io space off", 3);
        load_ctl(1, 1, 1, 1, 4'b1101);
        unclaimed("R1 R8 win1 disabled", 1);
        req("R1 win2 enabled", 2, 0, 0, 4'h8, 0, 1, 0, 1, 0, 5'd1, 4'h8, 0);
        load_ctl(1, 1, 1, 1, 4'b0111);
        unclaimed("R2 R8 io disabled", 3);
    endtask

    task automatic t_mode();
        cmd_mem_sp = 1; cmd_io_sp = 0;
        load_ctl(1, 0, 0, 1, 4'hF);
        req("R3 satellite uses cmd mem", 2, 0, 0, 4'h1, 0, 1, 0, 1, 0, 5'd1, 4'h1, 0);
        unclaimed("R3 satellite ignores status io", 3);
        load_ctl(1, 1, 0, 1, 4'hF);
        unclaimed("R3 host ignores cmd mem", 2);
        req("R3 host uses status io", 3, 0, 0, 4'h1, 0, 1, 0, 1, 0, 5'd1, 4'h1, 0);
        cmd_mem_sp = 0;
        load_ctl(1, 1, 1, 1, 4'hF);
    endtask

    task automatic t_io_pf();
        load_lane(3'b111, 4'h0, 4'd7);
        req("R6 io single read no pf", 3, 0, 0, 4'h6, 0, 1, 0, 1, 0, 5'd1, 4'h6, 0);
        req("R6 R7 io burst read err", 3, 0, 1, 4'hF, 0, 1, 1, 0, 0, 0, 0, 0);
        req("R9 io burst write", 3, 1, 1, 4'h5, 32'hCAFE0001, 1, 0, 1, 0, 5'd1, 4'h5, 32'hCAFE0001);
        req("R5 win0 code 7", 0, 0, 1, 4'h1, 0, 1, 0, 1, 1, 5'd8, 4'hF, 0);
        req("R5 win2 pf enabled", 2, 0, 1, 4'h1, 0, 1, 0, 1, 1, 5'd8, 4'hF, 0);
        load_lane(3'b001, 4'h0, 4'd15);
        req("R5 code 15", 0, 0, 0, 4'h1, 0, 1, 0, 1, 1, 5'd16, 4'hF, 0);
        req("R7 win1 pf off burst", 1, 0, 1, 4'hF, 0, 1, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_swap();
        load_lane(3'b000, 4'b0101, 4'd3);
        req("R9 win0 write swap", 0, 1, 0, 4'b0001, 32'h11223344, 1, 0, 1, 0, 5'd1,
            rev4(4'b0001), rev32(32'h11223344));
        req("R9 win1 write no swap", 1, 1, 1, 4'b0011, 32'h55667788, 1, 0, 1, 0, 5'd1,
            4'b0011, 32'h55667788);
        req("R9 win2 read be swap", 2, 0, 0, 4'b0011, 0, 1, 0, 1, 0, 5'd1, 4'b1100, 0);
    endtask

    task automatic t_rdret();
        @(negedge clk);
        rd_in_valid = 1; rd_in_win = 0; rd_in_data = 32'hAABBCCDD;
        req_valid = 1; req_win = 1; req_write = 1; req_burst = 0; req_be = 4'h1; req_wdata = 32'h1;
        @(posedge clk);
        #1;
        chk("R10", "rd_out_valid", rd_out_valid, 1);
        chk("R10", "swapped data", rd_out_data, rev32(32'hAABBCCDD));
        chk("R10", "concurrent ib_req", ib_req, 1);
        @(negedge clk);
        req_valid = 0;
        rd_in_win = 1; rd_in_data = 32'h01020304;
        @(posedge clk);
        #1;
        chk("R10", "unswapped data", rd_out_data, 32'h01020304);
        @(negedge clk);
        rd_in_valid = 0;
        @(posedge clk);
        #1;
        chk("R10", "valid drops", rd_out_valid, 0);
    endtask

    task automatic t_same_cycle();
        load_ctl(1, 1, 1, 1, 4'hF);
        @(negedge clk);
        cfg_load_ctl = 1; cfg_win_en = 4'b1110;
        req_valid = 1; req_win = 0; req_write = 0; req_burst = 0; req_be = 4'h1;
        @(posedge clk);
        #1;
        chk("R11", "claim under old config", rsp_claim, 1);
        chk("R11", "ib_req under old config", ib_req, 1);
        @(negedge clk);
        cfg_load_ctl = 0;
        @(posedge clk);
        #1;
        req_valid = 0;
        chk("R11", "claim under new config", rsp_claim, 0);
        chk("R8", "no ib_req when disabled", ib_req, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_defaults();
        t_enable();
        t_mode();
        t_io_pf();
        t_swap();
        t_rdret();
        t_same_cycle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule